// File: doc/BRIEF.md
# Quasi-Bidirectional Port

This block is one 8-bit general-purpose I/O port of the kind found on small 8-bit controllers. Each pin owns an output latch that the processor loads through a write strobe. The pad is driven only by an open-drain pulldown, which is active while the latch bit is 0. Writing a 1 turns the pulldown off. An optional weak pullup then holds the pin high, and any external device may pull it low. A pin therefore serves as an input only after a 1 has been written to its latch.

The processor has two distinct read paths. The pin path returns the synchronised pad level. The latch path returns the stored latch value. Read-modify-write updates (AND, OR, XOR with a mask) are applied inside the block to the latch contents, never to the pad level. An external device that holds a released pin low therefore cannot corrupt that pin's latch. Bit 0 is the least significant pin and bit 7 the most significant.

Top module: `qbport`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every latch bit is 1, `pad_pull_low` is all 0 and a latch read returns all ones.
- R2: A write with `wr_op` = 2'b00 (load) stores `wr_data` in the latch at the clock edge. From that edge on, `pad_pull_low[i]` is 1 exactly where bit i of the stored value is 0.
- R3: While `wr_en` is 0 the latch holds its value, whatever `wr_op` and `wr_data` do.
- R4: The `wr_op` codes 2'b01, 2'b10 and 2'b11 replace the latch with latch AND `wr_data`, latch OR `wr_data` and latch XOR `wr_data`. These operations use the stored latch value even when an external device holds a released pin low.
- R5: With `rd_latch_en` = 1, `rd_data` equals the latch contents in the same cycle.
- R6: With only `rd_pin_en` = 1, `rd_data` equals the level of `pad_in` as sampled by `SYNC_STAGES` (default 2) clock edges.
- R7: With both read strobes at 1, the latch path wins.
- R8: With neither read strobe at 1, `rd_data` is all zeros.
- R9: With `PULLUP_EN` = 1, `pad_pullup_en` equals the latch contents. With `PULLUP_EN` = 0 it is all zeros. A pin never has its pullup and its pulldown enabled together.
- R10: A pin whose latch bit is 0 reads 0 on the pin path regardless of any external driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe to the latch |
| wr_op | input | 2 | Write operation: 00 load, 01 AND, 10 OR, 11 XOR |
| wr_data | input | 8 | Write data or mask |
| rd_pin_en | input | 1 | Read strobe for the pin level |
| rd_latch_en | input | 1 | Read strobe for the latch contents |
| rd_data | output | 8 | Read data to the internal bus |
| pad_in | input | 8 | Level seen at the pads |
| pad_pull_low | output | 8 | Pulldown enable per pin (1 pulls the pad low) |
| pad_pullup_en | output | 8 | Weak pullup enable per pin |

## Verification
A wrong latch bit appears at `pad_pull_low` on the edge after the write, and on the latch read path in that same cycle. A bad bit in the pin synchroniser appears on the pin read path `SYNC_STAGES` edges after the pad changes. The RMW case is the subtle one. If an operation used the pad level instead of the latch, the error would stay hidden until a pin held low externally was released. At that point the pin would stay low, and the latch read would show 0 right after the operation.

// File: rtl/qbport_pkg.sv
package qbport_pkg;
  typedef enum logic [1:0] {
    QB_LOAD = 2'b00,
    QB_AND  = 2'b01,
    QB_OR   = 2'b10,
    QB_XOR  = 2'b11
  } qb_op_e;
endpackage

// File: rtl/qbport_latch.sv
module qbport_latch
  import qbport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  qb_op_e       wr_op,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] latch_q
);
  logic [W-1:0] latch_d;
  logic [W-1:0] op_result;

  // Combine the stored value with the mask: the pad level is never an operand
  always_comb begin
    unique case (wr_op)
      QB_LOAD: op_result = wr_data;
      QB_AND:  op_result = latch_q & wr_data;
      QB_OR:   op_result = latch_q | wr_data;
      QB_XOR:  op_result = latch_q ^ wr_data;
      default: op_result = wr_data;
    endcase
  end

  always_comb begin
    latch_d = latch_q;
    if (wr_en) latch_d = op_result;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '1;
    else        latch_q <= latch_d;
  end
endmodule

// File: rtl/qbport_sync.sv
module qbport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stage_d[s] = din;
      end else begin : g_next
        assign stage_d[s] = stage_q[s-1];
      end
      // Reset to ones: released pins with a pullup read high
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qbport_rdmux.sv
module qbport_rdmux #(
  parameter int W = 8
) (
  input  logic         rd_pin_en,
  input  logic         rd_latch_en,
  input  logic [W-1:0] pin_val,
  input  logic [W-1:0] latch_val,
  output logic [W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_latch_en)    rd_data = latch_val;
    else if (rd_pin_en) rd_data = pin_val;
  end
endmodule

// File: rtl/qbport.sv
module qbport
  import qbport_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit PULLUP_EN   = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_op,
  input  logic [W-1:0] wr_data,
  input  logic         rd_pin_en,
  input  logic         rd_latch_en,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_pull_low,
  output logic [W-1:0] pad_pullup_en
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_core_n;
  logic [W-1:0]          latch_q;
  logic [W-1:0]          pin_sync;
  qb_op_e                op_e;

  // Reset asserts at once and is released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[RST_STAGES-1];

  assign op_e = qb_op_e'(wr_op);

  qbport_latch #(.W(W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_en   (wr_en),
    .wr_op   (op_e),
    .wr_data (wr_data),
    .latch_q (latch_q)
  );

  qbport_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (pad_in),
    .dout  (pin_sync)
  );

  qbport_rdmux #(.W(W)) u_rdmux (
    .rd_pin_en   (rd_pin_en),
    .rd_latch_en (rd_latch_en),
    .pin_val     (pin_sync),
    .latch_val   (latch_q),
    .rd_data     (rd_data)
  );

  // Open-drain stage driven by the inverted latch
  assign pad_pull_low = ~latch_q;

  generate
    if (PULLUP_EN) begin : g_pullup
      assign pad_pullup_en = latch_q;
    end else begin : g_no_pullup
      assign pad_pullup_en = '0;
    end
  endgenerate
endmodule

// File: rtl/qbport_chk.sv
module qbport_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_op,
  input logic [W-1:0] wr_data,
  input logic         rd_pin_en,
  input logic         rd_latch_en,
  input logic [W-1:0] rd_data,
  input logic [W-1:0] pad_pull_low,
  input logic [W-1:0] pad_pullup_en
);
  // R2
  load_drives_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == 2'b00) |=> (pad_pull_low == ~$past(wr_data)));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pad_pull_low));

  // R5
  latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_latch_en |-> (rd_data == ~pad_pull_low));

  // R8
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_latch_en && !rd_pin_en) |-> (rd_data == '0));

  // R9
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pull_low & pad_pullup_en) == '0);
endmodule

bind qbport qbport_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .wr_en         (wr_en),
  .wr_op         (wr_op),
  .wr_data       (wr_data),
  .rd_pin_en     (rd_pin_en),
  .rd_latch_en   (rd_latch_en),
  .rd_data       (rd_data),
  .pad_pull_low  (pad_pull_low),
  .pad_pullup_en (pad_pullup_en)
);

// File: tb/qbport_tb.sv
module qbport_tb;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         wr_en;
  logic [1:0]   wr_op;
  logic [W-1:0] wr_data;
  logic         rd_pin_en;
  logic         rd_latch_en;
  logic [W-1:0] rd_data;
  logic [W-1:0] pad_in;
  logic [W-1:0] pad_pull_low;
  logic [W-1:0] pad_pullup_en;
  logic [W-1:0] ext_low;

  int checks;
  int failures;
  int cycles;
  bit finished;
  logic [W-1:0] exp_latch;

  qbport u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_op         (wr_op),
    .wr_data       (wr_data),
    .rd_pin_en     (rd_pin_en),
    .rd_latch_en   (rd_latch_en),
    .rd_data       (rd_data),
    .pad_in        (pad_in),
    .pad_pull_low  (pad_pull_low),
    .pad_pullup_en (pad_pullup_en)
  );

  // Wired-AND pad: low if pulled down inside or outside; high through the weak pullup
  function automatic logic [W-1:0] pad_level(logic [W-1:0] pd, logic [W-1:0] ext,
                                             logic [W-1:0] pu);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++)
      r[i] = (pd[i] || ext[i]) ? 1'b0 : (pu[i] ? 1'b1 : 1'b1);
    return r;
  endfunction

  assign pad_in = pad_level(pad_pull_low, ext_low, pad_pullup_en);

  function automatic logic [W-1:0] apply_op(logic [1:0] op, logic [W-1:0] cur,
                                            logic [W-1:0] d);
    case (op)
      2'b00:   return d;
      2'b01:   return cur & d;
      2'b10:   return cur | d;
      default: return cur ^ d;
    endcase
  endfunction

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [1:0] op, logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_op = op; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    exp_latch = apply_op(op, exp_latch, d);
  endtask

  task automatic check_latch(string req);
    @(negedge clk);
    rd_latch_en = 1'b1; rd_pin_en = 1'b0;
    #1;
    check(req, rd_data, exp_latch);
    check(req, pad_pull_low, ~exp_latch);
    rd_latch_en = 1'b0;
  endtask

  task automatic check_pin(string req);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_pin_en = 1'b1; rd_latch_en = 1'b0;
    #1;
    check(req, rd_data, exp_latch & ~ext_low);
    rd_pin_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'h5eed_0051));
    checks = 0; failures = 0; cycles = 0; finished = 1'b0;
    wr_en = 0; wr_op = 0; wr_data = 0; rd_pin_en = 0; rd_latch_en = 0;
    ext_low = '0;
    exp_latch = '1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: during reset
    rd_latch_en = 1'b1; #1;
    check("R1", rd_data, 8'hFF);
    check("R1", pad_pull_low, 8'h00);
    rd_latch_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    check_latch("R1");

    // R8: idle bus reads zero
    @(negedge clk); #1;
    check("R8", rd_data, 8'h00);

    // R2 directed load, R9 pullup follows latch
    do_write(2'b00, 8'hA5);
    check_latch("R2");
    check("R9", pad_pullup_en, exp_latch);
    check("R9", pad_pullup_en & pad_pull_low, 8'h00);

    // R3: strobe low while data and op move
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      wr_data = $urandom(); wr_op = $urandom();
    end
    check_latch("R3");

    // R10: pin with latch 0 reads 0 even with no external driver
    ext_low = '0;
    check_pin("R10");

    // R4: RMW with external low on released pins must not disturb latch
    do_write(2'b00, 8'hFF);
    ext_low = 8'h0F;
    check_pin("R6");
    do_write(2'b10, 8'h80);
    check_latch("R4");
    check("R4", exp_latch, 8'hFF);
    ext_low = '0;
    check_pin("R4");
    do_write(2'b01, 8'h3C);
    check_latch("R4");
    do_write(2'b11, 8'hFF);
    check_latch("R4");

    // R7: both strobes, latch wins
    ext_low = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd_pin_en = 1'b1; rd_latch_en = 1'b1; #1;
    check("R7", rd_data, exp_latch);
    rd_pin_en = 1'b0; rd_latch_en = 1'b0;
    ext_low = '0;

    // Constrained random mix
    for (int n = 0; n < 40; n++) begin
      logic [1:0] op;
      logic [W-1:0] d;
      op = 2'($urandom());
      d = 8'($urandom());
      ext_low = 8'($urandom()) & 8'($urandom());
      held = exp_latch;
      do_write(op, d);
      check_latch((op == 2'b00) ? "R2" : "R4");
      check("R4", exp_latch, apply_op(op, held, d));
      check("R9", pad_pullup_en, exp_latch);
      check_pin("R6");
    end

    ext_low = '0;
    check_pin("R10");
    finish_run();
  end
endmodule